// File: doc/BRIEF.md
# Quadrature ABZ output formatter

This block converts single-step phase pulses from an interpolator into incremental quadrature outputs. Each step moves a two-bit A/B state one position forward or backward. A cycle counter tracks how many full A/B cycles have passed inside one input sine period. The counter's range comes from the programmed interpolation factor.

An index (Z) output is formed from a raw zero-enable input and two further gates. The first is a four-bit mask that selects the A/B states in which the index may appear. The second, when enabled, requires a match between a chosen cycle count and the counter. The index register either samples this gate on every clock or updates only in cycles that move the A/B state. A configuration byte sets inversion for each channel and can exchange A and B. Every channel is driven as a complementary P/N pair.

Top module: `abz_formatter`

## Requirements
- R1: After reset the cycle counter is 0, the A/B state is (A,B)=(1,1) and the internal index is 0, so with an all-zero configuration pa=1, pb=1, pz=0.
- R2: Each clock with step_up=1 and step_dn=0 advances the A/B state one position through (1,1) → (1,0) → (0,0) → (0,1) → (1,1). The outputs show the new state in the cycle after the clock edge.
- R3: Each clock with step_dn=1 and step_up=0 moves the state one position backward along the same sequence. Leaving (1,1) backward decrements the cycle counter, and from 0 it wraps to factor−1.
- R4: A clock with neither step input, or with both, leaves the A/B state and the cycle counter unchanged.
- R5: Moving forward from (0,1) to (1,1) increments the cycle counter. Once the counter is at factor−1 it wraps to 0 instead, with factor = ipf_i (a value of 0 behaves as 1).
- R6: The index is the AND of zero_en_i, the mask bit for the A/B state (zcfg bit 3 for (1,1), bit 2 for (1,0), bit 1 for (0,0), bit 0 for (0,1)) and, when zpos_i[7]=1, equality of the cycle counter with zpos_i[6:0].
- R7: With zpos_i[7]=1 and zpos_i[6:0] greater than factor−1, the index never becomes 1.
- R8: With zsync_i=0 the index register loads the gate value computed from the state after the current edge on every clock. A change of zero_en_i therefore shows on pz one clock later.
- R9: With zsync_i=1 the index register loads only on clocks that move the A/B state. On any other clock pz holds, whatever zero_en_i does.
- R10: out_cfg_i bit 7 inverts channel 1 (pa), bit 6 inverts channel 2 (pb) and bit 5 inverts the index (pz). Each of na, nb and nz is always the complement of its P output.
- R11: With out_cfg_i bit 4=0, channel 1 carries A and channel 2 carries B. With bit 4=1 the two are exchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| step_up | input | 1 | Forward phase step, one per clock |
| step_dn | input | 1 | Backward phase step, one per clock |
| ipf_i | input | 8 | Interpolation factor (A/B cycles per sine period) |
| zero_en_i | input | 1 | Raw zero-enable from the comparator path |
| out_cfg_i | input | 8 | [7] invert ch1, [6] invert ch2, [5] invert index, [4] swap A/B, [3:0] index state mask |
| zpos_i | input | 8 | [7] cycle-count gate enable, [6:0] selected cycle count |
| zsync_i | input | 1 | 1: index updates only with A/B moves; 0: every clock |
| pa | output | 1 | Channel 1 positive |
| na | output | 1 | Channel 1 negative |
| pb | output | 1 | Channel 2 positive |
| nb | output | 1 | Channel 2 negative |
| pz | output | 1 | Index positive |
| nz | output | 1 | Index negative |

## Verification
A mixed run of forward, backward, idle and conflicting steps exercises the sequencer against a reference model. This separates a wrong step direction or a missed hold from a correct walk. Long forward and backward runs with the index tied to one counter value and one state confirm that the counter wraps at the factor in both directions. A selected count just beyond the factor is compared with one inside it, which separates "never released" from a wrong comparison. Toggling zero_en_i between steps with each sync setting shows whether the index follows the raw enable or waits for an A/B move. A sweep of the inversion and swap bits then tells channel mapping apart from polarity.

// File: rtl/abz_pkg.sv
package abz_pkg;
  // A/B state codes, numbered in forward order.
  localparam logic [1:0] ST_11 = 2'd0;
  localparam logic [1:0] ST_10 = 2'd1;
  localparam logic [1:0] ST_00 = 2'd2;
  localparam logic [1:0] ST_01 = 2'd3;

  function automatic logic chan_a(input logic [1:0] st);
    return (st == ST_11) || (st == ST_10);
  endfunction

  function automatic logic chan_b(input logic [1:0] st);
    return (st == ST_11) || (st == ST_01);
  endfunction
endpackage

// File: rtl/abz_seq.sv
module abz_seq
  import abz_pkg::*;
#(
  parameter int POS_W = 7,
  parameter int IPF_W = POS_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_up,
  input  logic             step_dn,
  input  logic [IPF_W-1:0] ipf_i,
  output logic [1:0]       st_q,
  output logic [POS_W-1:0] pos_q,
  output logic [1:0]       st_nx,
  output logic [POS_W-1:0] pos_nx,
  output logic             moved
);
  logic [IPF_W-1:0] ipf_m1;
  logic [POS_W-1:0] pos_max;

  assign ipf_m1  = ipf_i - 1'b1;
  assign pos_max = (ipf_i == '0) ? '0 : ipf_m1[POS_W-1:0];

  always_comb begin
    moved  = step_up ^ step_dn;
    st_nx  = st_q;
    pos_nx = pos_q;
    if (step_up && !step_dn) begin
      st_nx = st_q + 2'd1;
      if (st_q == ST_01) begin
        pos_nx = (pos_q >= pos_max) ? '0 : pos_q + 1'b1;
      end
    end else if (step_dn && !step_up) begin
      st_nx = st_q - 2'd1;
      if (st_q == ST_11) begin
        pos_nx = (pos_q == '0 || pos_q > pos_max) ? pos_max : pos_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_11;
      pos_q <= '0;
    end else if (moved) begin
      st_q  <= st_nx;
      pos_q <= pos_nx;
    end
  end

  // R4: no move keeps state and count
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(step_up ^ step_dn) |=> ($stable(st_q) && $stable(pos_q)));

  // R5: forward wrap of the cycle counter
  a_r5_wrap_up: assert property (@(posedge clk) disable iff (!rst_n)
    (step_up && !step_dn && st_q == ST_01 && pos_q == pos_max) |=> (pos_q == '0));

  // R3: backward wrap of the cycle counter
  a_r3_wrap_dn: assert property (@(posedge clk) disable iff (!rst_n)
    (step_dn && !step_up && st_q == ST_11 && pos_q == '0) |=> (pos_q == $past(pos_max)));
endmodule

// File: rtl/abz_zgate.sv
module abz_zgate
  import abz_pkg::*;
#(
  parameter int POS_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             zero_en_i,
  input  logic [3:0]       st_mask,
  input  logic             cnt_gate_en,
  input  logic [POS_W-1:0] cnt_sel,
  input  logic             sync_i,
  input  logic             moved,
  input  logic [1:0]       st_nx,
  input  logic [POS_W-1:0] pos_nx,
  output logic             z_q
);
  logic mask_bit;
  logic gate;
  logic load;
  logic z_d;

  always_comb begin
    case (st_nx)
      ST_11:   mask_bit = st_mask[3];
      ST_10:   mask_bit = st_mask[2];
      ST_00:   mask_bit = st_mask[1];
      default: mask_bit = st_mask[0];
    endcase
  end

  always_comb begin
    gate = zero_en_i && mask_bit && (!cnt_gate_en || (pos_nx == cnt_sel));
    load = !sync_i || moved;
    z_d  = load ? gate : z_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) z_q <= 1'b0;
    else        z_q <= z_d;
  end

  // R9: synchronised index holds without an A/B move
  a_r9_sync_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_i && !moved) |=> $stable(z_q));

  // R6: index can only rise from an active raw enable
  a_r6_needs_raw: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(z_q) |-> $past(zero_en_i));
endmodule

// File: rtl/abz_outmap.sv
module abz_outmap
  import abz_pkg::*;
(
  input  logic [1:0] st,
  input  logic       z,
  input  logic [3:0] pol_cfg,
  output logic       pa,
  output logic       na,
  output logic       pb,
  output logic       nb,
  output logic       pz,
  output logic       nz
);
  logic a_raw;
  logic b_raw;
  logic ch1;
  logic ch2;

  always_comb begin
    a_raw = chan_a(st);
    b_raw = chan_b(st);
    ch1   = pol_cfg[0] ? b_raw : a_raw;
    ch2   = pol_cfg[0] ? a_raw : b_raw;
    pa    = ch1 ^ pol_cfg[3];
    pb    = ch2 ^ pol_cfg[2];
    pz    = z ^ pol_cfg[1];
    na    = ~pa;
    nb    = ~pb;
    nz    = ~pz;
  end
endmodule

// File: rtl/abz_formatter.sv
module abz_formatter
  import abz_pkg::*;
#(
  parameter int POS_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_up,
  input  logic             step_dn,
  input  logic [POS_W:0]   ipf_i,
  input  logic             zero_en_i,
  input  logic [7:0]       out_cfg_i,
  input  logic [POS_W:0]   zpos_i,
  input  logic             zsync_i,
  output logic             pa,
  output logic             na,
  output logic             pb,
  output logic             nb,
  output logic             pz,
  output logic             nz
);
  localparam int IPF_W = POS_W + 1;

  logic [1:0]       st_q;
  logic [1:0]       st_nx;
  logic [POS_W-1:0] pos_q;
  logic [POS_W-1:0] pos_nx;
  logic             moved;
  logic             z_q;

  abz_seq #(.POS_W(POS_W), .IPF_W(IPF_W)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .step_up (step_up),
    .step_dn (step_dn),
    .ipf_i   (ipf_i),
    .st_q    (st_q),
    .pos_q   (pos_q),
    .st_nx   (st_nx),
    .pos_nx  (pos_nx),
    .moved   (moved)
  );

  abz_zgate #(.POS_W(POS_W)) u_zgate (
    .clk         (clk),
    .rst_n       (rst_n),
    .zero_en_i   (zero_en_i),
    .st_mask     (out_cfg_i[3:0]),
    .cnt_gate_en (zpos_i[POS_W]),
    .cnt_sel     (zpos_i[POS_W-1:0]),
    .sync_i      (zsync_i),
    .moved       (moved),
    .st_nx       (st_nx),
    .pos_nx      (pos_nx),
    .z_q         (z_q)
  );

  abz_outmap u_outmap (
    .st      (st_q),
    .z       (z_q),
    .pol_cfg (out_cfg_i[7:4]),
    .pa      (pa),
    .na      (na),
    .pb      (pb),
    .nb      (nb),
    .pz      (pz),
    .nz      (nz)
  );

  // R1: state and count sit at their reset values in the first cycle after reset
  a_r1_reset_state: assert property (@(posedge clk)
    (!$past(rst_n) && rst_n) |-> (st_q == ST_11 && pos_q == '0 && !z_q));
endmodule

// File: tb/tb_abz_formatter.sv
`timescale 1ns/1ps
module tb_abz_formatter;
  logic       clk;
  logic       rst_n;
  logic       step_up;
  logic       step_dn;
  logic [7:0] ipf_i;
  logic       zero_en_i;
  logic [7:0] out_cfg_i;
  logic [7:0] zpos_i;
  logic       zsync_i;
  logic       pa, na, pb, nb, pz, nz;

  int checks;
  int errors;
  int m_st;
  int m_pos;
  bit m_z;
  int zcount;

  abz_formatter dut (
    .clk(clk), .rst_n(rst_n), .step_up(step_up), .step_dn(step_dn),
    .ipf_i(ipf_i), .zero_en_i(zero_en_i), .out_cfg_i(out_cfg_i),
    .zpos_i(zpos_i), .zsync_i(zsync_i),
    .pa(pa), .na(na), .pb(pb), .nb(nb), .pz(pz), .nz(nz)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // stimulus rows: {up, dn, zen, sync}
  localparam logic [3:0] VEC [32] = '{
    4'b0010, 4'b1010, 4'b1010, 4'b1010, 4'b1010, 4'b1010, 4'b1110, 4'b0000,
    4'b0110, 4'b0110, 4'b0110, 4'b0110, 4'b0010, 4'b0000, 4'b1011, 4'b1011,
    4'b1011, 4'b0001, 4'b1001, 4'b0011, 4'b0111, 4'b0101, 4'b1111, 4'b1011,
    4'b1011, 4'b0110, 4'b1110, 4'b1010, 4'b1010, 4'b1010, 4'b0010, 4'b0000
  };

  function automatic logic [5:0] expv();
    logic a, b, c1, c2, p1, p2, p3;
    a  = (m_st < 2);
    b  = (m_st == 0) || (m_st == 3);
    c1 = out_cfg_i[4] ? b : a;
    c2 = out_cfg_i[4] ? a : b;
    p1 = c1 ^ out_cfg_i[7];
    p2 = c2 ^ out_cfg_i[6];
    p3 = m_z ^ out_cfg_i[5];
    return {p1, ~p1, p2, ~p2, p3, ~p3};
  endfunction

  task automatic model_step(input bit up, input bit dn, input bit zen);
    int pmax;
    int nst;
    int npos;
    bit mb;
    bit g;
    pmax = (ipf_i == 0) ? 0 : int'(ipf_i) - 1;
    nst = m_st;
    npos = m_pos;
    if (up && !dn) begin
      nst = (m_st + 1) % 4;
      if (m_st == 3) npos = (m_pos >= pmax) ? 0 : m_pos + 1;
    end else if (dn && !up) begin
      nst = (m_st + 3) % 4;
      if (m_st == 0) npos = (m_pos == 0 || m_pos > pmax) ? pmax : m_pos - 1;
    end
    mb = out_cfg_i[3 - nst];
    g  = zen && mb && (!zpos_i[7] || (npos == int'(zpos_i[6:0])));
    if (!zsync_i || (up ^ dn)) m_z = g;
    m_st = nst;
    m_pos = npos;
  endtask

  task automatic chk(input string tag);
    logic [5:0] act;
    logic [5:0] exp;
    act = {pa, na, pb, nb, pz, nz};
    exp = expv();
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: {pa,na,pb,nb,pz,nz} actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic cyc(input bit up, input bit dn, input bit zen);
    step_up = up;
    step_dn = dn;
    zero_en_i = zen;
    @(posedge clk);
    model_step(up, dn, zen);
    @(negedge clk);
    if (pz) zcount++;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    step_up = 1'b0;
    step_dn = 1'b0;
    zero_en_i = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    m_st = 0;
    m_pos = 0;
    m_z = 1'b0;
  endtask

  initial begin
    #(8 * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    checks = 0;
    errors = 0;
    zcount = 0;
    ipf_i = 8'd3;
    out_cfg_i = 8'h00;
    zpos_i = 8'h00;
    zsync_i = 1'b0;
    @(negedge clk);
    do_reset();

    // R1: reset values
    chk("R1 reset");
    checks++;
    if ({pa, pb, pz} !== 3'b110) begin
      errors++;
      $display("FAIL R1: {pa,pb,pz} actual=%b expected=110", {pa, pb, pz});
    end

    // table walk: ipf=3, index only in state (1,1), count gate at 1
    out_cfg_i = 8'h08;
    zpos_i = 8'h81;
    for (int i = 0; i < 32; i++) begin
      zsync_i = VEC[i][0];
      cyc(VEC[i][3], VEC[i][2], VEC[i][1]);
      if (VEC[i][3] && !VEC[i][2])      chk("R2 fwd step / R6 gate");
      else if (VEC[i][2] && !VEC[i][3]) chk("R3 back step / R6 gate");
      else if (VEC[i][0])               chk("R4 no move / R9 hold");
      else                              chk("R4 no move / R8 follow");
    end

    // R5: forward wrap, index tied to count 0 in state (1,1)
    do_reset();
    zsync_i = 1'b0;
    zpos_i = 8'h80;
    out_cfg_i = 8'h08;
    cyc(0, 0, 1);
    chk("R5 count0 index");
    for (int k = 0; k < 12; k++) begin
      cyc(1, 0, 1);
      if (k % 4 == 3) chk("R5 forward wrap");
    end
    // R3: backward wrap from 0 to factor-1
    for (int k = 0; k < 12; k++) begin
      cyc(0, 1, 1);
      if (k % 4 == 3) chk("R3 backward wrap");
    end

    // R7: selected count beyond factor-1 gives no index
    do_reset();
    out_cfg_i = 8'h0F;
    zpos_i = 8'h83;
    zcount = 0;
    for (int k = 0; k < 24; k++) cyc(1, 0, 1);
    checks++;
    if (zcount != 0) begin
      errors++;
      $display("FAIL R7: index pulses actual=%0d expected=0", zcount);
    end
    zpos_i = 8'h82;
    zcount = 0;
    for (int k = 0; k < 24; k++) cyc(1, 0, 1);
    checks++;
    if (zcount != 8) begin
      errors++;
      $display("FAIL R7: in-range index cycles actual=%0d expected=8", zcount);
    end

    // R8 / R9: raw enable toggles between steps
    do_reset();
    out_cfg_i = 8'h08;
    zpos_i = 8'h00;
    zsync_i = 1'b0;
    cyc(0, 0, 1);
    chk("R8 follows raw rise");
    cyc(0, 0, 0);
    chk("R8 follows raw fall");
    zsync_i = 1'b1;
    cyc(0, 0, 1);
    chk("R9 holds without move");
    cyc(1, 0, 1);
    cyc(1, 0, 1);
    cyc(1, 0, 1);
    cyc(1, 0, 1);
    chk("R9 loads on move");
    cyc(0, 0, 0);
    chk("R9 holds after raw fall");

    // R10 / R11: polarity and swap sweep over every state
    for (int c = 0; c < 16; c++) begin
      out_cfg_i = {c[3:0], 4'hF};
      zsync_i = 1'b0;
      for (int s = 0; s < 4; s++) begin
        cyc(1, 0, s[0]);
        chk(c[0] ? "R11 swap / R10 polarity" : "R10 polarity / R11 no swap");
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule